// File: doc/BRIEF.md
# Atomic Wide Register Staging Buffer

This block holds a hardware register that is wider than the software register bus. Software sees it as a row of bus-width sub-registers at consecutive word offsets above a base address. Writes land in a staging buffer. The full-width hardware copy changes only on a trigger edge, and then all of its bits change at once. Hardware therefore never sees a register that is only partly updated.

In the read direction the roles swap. A trigger snapshots a wide value supplied by hardware into the staging buffer in one cycle. Software can then read that value one slice at a time without tearing.

The trigger source is chosen at elaboration time. It can be one of five events:
- a software write to the lowest slice;
- a software write to the highest slice;
- a software read of the lowest slice;
- a software read of the highest slice;
- an external trigger pin.

A one-cycle pulse marks each transfer.

Top module: `wide_reg_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the staging buffer and `hw_q_o` clear to zero and `xfer_o` clears to 0. This is a synchronous, active-low reset.
- R2: Slice i (slice 0 holds the least significant bits) is selected only when `addr_i` equals exactly BASE_ADDR + i*DATA_W/8. Writes to any other address change nothing. A read of any other address returns zero.
- R3: A write to a selected slice stores (wdata AND m) OR (old AND NOT m). Here m sets byte k of the slice from `be_i[k]`, so be bit 0 covers bits 7:0.
- R4: A read of a selected slice returns the staging buffer contents, not `hw_q_o`. Written data is readable before any commit.
- R5: In the write-low and write-high trigger modes, a write to slice 0 or to slice N-1 respectively loads all of `hw_q_o` at that edge. The triggering slice takes its merged new value, and the other slices take their buffered values. No other write changes `hw_q_o`.
- R6: In the read-low and read-high trigger modes, a read of slice 0 or slice N-1 respectively does three things. It loads every slice of the buffer from `hw_d_i` at that edge. It returns the matching `hw_d_i` slice in the same cycle. It discards any write in that cycle. In these modes `hw_q_o` stays zero.
- R7: In the external mode, `trig_i` high at an edge loads `hw_q_o` with the buffer contents as they stood before that edge. Bus accesses never load `hw_q_o` in this mode.
- R8: `xfer_o` is high for exactly the cycle after each trigger edge, which is the cycle in which the new wide value is first visible.
- R9: `hw_q_o` never changes in a cycle where `xfer_o` is low. It therefore never shows a mix of old and new slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Bus byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte enables for the write merge |
| rdata_o | output | DATA_W | Read data (combinational) |
| trig_i | input | 1 | External trigger (external mode) |
| hw_q_o | output | DATA_W*SLICES | Wide register seen by hardware |
| hw_d_i | input | DATA_W*SLICES | Wide value captured on a read trigger |
| xfer_o | output | 1 | One-cycle transfer pulse |

## Verification
The hardest case to reach is a trigger that coincides with a change in the same cycle. One example is a partial-byte write to the triggering slice, where the commit must use the merged value rather than either the old buffer or the raw bus data. Another is the external trigger arriving together with a write, where the commit must use the value buffered before that write. The stimulus drives both events in one cycle to reach these cases. A per-cycle monitor confirms that the wide output only moves in pulse cycles. The read direction changes `hw_d_i` between capture and later reads, so that a stale snapshot can be told apart from a live one.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [2:0] {
      TRIG_WR_LSB = 3'd0,
      TRIG_WR_MSB = 3'd1,
      TRIG_RD_LSB = 3'd2,
      TRIG_RD_MSB = 3'd3,
      TRIG_EXT    = 3'd4
   } trig_e;
endpackage

// File: rtl/wbuf_decode.sv
module wbuf_decode #(
   parameter int ADDR_W    = 8,
   parameter int SLICES    = 4,
   parameter int STRIDE    = 4,
   parameter int BASE_ADDR = 'h40
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SLICES-1:0] hit_o
);
   for (genvar s = 0; s < SLICES; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BASE_ADDR + s*STRIDE);
      assign hit_o[s] = (addr_i == SLOT);
   end
endmodule

// File: rtl/wbuf_stage.sv
module wbuf_stage #(
   parameter int DATA_W = 32,
   parameter int SLICES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SLICES-1:0]        wr_sel_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [DATA_W/8-1:0]      be_i,
   input  logic                     cap_en_i,
   input  logic [DATA_W*SLICES-1:0] cap_data_i,
   output logic [DATA_W*SLICES-1:0] buf_q_o,
   output logic [DATA_W*SLICES-1:0] merged_o
);
   localparam int BYTES = DATA_W / 8;

   logic [DATA_W-1:0] bit_mask;

   for (genvar b = 0; b < BYTES; b++) begin : g_mask
      assign bit_mask[b*8 +: 8] = {8{be_i[b]}};
   end

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      logic [DATA_W-1:0] cur;
      logic [DATA_W-1:0] upd;

      assign cur = buf_q_o[s*DATA_W +: DATA_W];
      assign upd = (wdata_i & bit_mask) | (cur & ~bit_mask);
      assign merged_o[s*DATA_W +: DATA_W] = wr_sel_i[s] ? upd : cur;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            buf_q_o[s*DATA_W +: DATA_W] <= '0;
         end else if (cap_en_i) begin
            buf_q_o[s*DATA_W +: DATA_W] <= cap_data_i[s*DATA_W +: DATA_W];
         end else if (wr_sel_i[s]) begin
            buf_q_o[s*DATA_W +: DATA_W] <= upd;
         end
      end
   end
endmodule

// File: rtl/wbuf_commit.sv
module wbuf_commit #(
   parameter int WIDE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              load_i,
   input  logic [WIDE_W-1:0] load_val_i,
   output logic [WIDE_W-1:0] hw_q_o,
   output logic              xfer_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_q_o <= '0;
         xfer_o <= 1'b0;
      end else begin
         xfer_o <= fire_i;
         if (load_i) begin
            hw_q_o <= load_val_i;
         end
      end
   end
endmodule

// File: rtl/wide_reg_stage.sv
module wide_reg_stage
   import wbuf_pkg::*;
#(
   parameter int    DATA_W    = 32,
   parameter int    SLICES    = 4,
   parameter int    ADDR_W    = 8,
   parameter int    BASE_ADDR = 'h40,
   parameter trig_e TRIG      = TRIG_WR_MSB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     wr_i,
   input  logic                     rd_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [DATA_W/8-1:0]      be_i,
   output logic [DATA_W-1:0]        rdata_o,
   input  logic                     trig_i,
   output logic [DATA_W*SLICES-1:0] hw_q_o,
   input  logic [DATA_W*SLICES-1:0] hw_d_i,
   output logic                     xfer_o
);
   localparam int WIDE_W = DATA_W * SLICES;
   localparam int STRIDE = DATA_W / 8;
   localparam int TIDX   = (TRIG == TRIG_WR_LSB || TRIG == TRIG_RD_LSB) ? 0 : SLICES - 1;
   localparam bit IS_RD  = (TRIG == TRIG_RD_LSB || TRIG == TRIG_RD_MSB);
   localparam bit IS_EXT = (TRIG == TRIG_EXT);

   if (SLICES < 2 || SLICES > 4) begin : g_bad_slices
      $error("wide_reg_stage: SLICES must be 2..4");
   end
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("wide_reg_stage: DATA_W must be a multiple of 8");
   end

   logic [SLICES-1:0] hit;
   logic [SLICES-1:0] wr_hit;
   logic [SLICES-1:0] rd_hit;
   logic              fire;
   logic              cap_en;
   logic              hw_load;
   logic [WIDE_W-1:0] buf_q;
   logic [WIDE_W-1:0] merged;
   logic [WIDE_W-1:0] load_val;

   wbuf_decode #(
      .ADDR_W   (ADDR_W),
      .SLICES   (SLICES),
      .STRIDE   (STRIDE),
      .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .addr_i(addr_i),
      .hit_o (hit)
   );

   assign wr_hit = hit & {SLICES{wr_i}};
   assign rd_hit = hit & {SLICES{rd_i}};

   always_comb begin
      if (IS_EXT)     fire = trig_i;
      else if (IS_RD) fire = rd_hit[TIDX];
      else            fire = wr_hit[TIDX];
   end

   assign cap_en   = IS_RD && fire;
   assign hw_load  = fire && !IS_RD;
   assign load_val = IS_EXT ? buf_q : merged;

   wbuf_stage #(
      .DATA_W(DATA_W),
      .SLICES(SLICES)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel_i  (wr_hit),
      .wdata_i   (wdata_i),
      .be_i      (be_i),
      .cap_en_i  (cap_en),
      .cap_data_i(hw_d_i),
      .buf_q_o   (buf_q),
      .merged_o  (merged)
   );

   wbuf_commit #(
      .WIDE_W(WIDE_W)
   ) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .load_i    (hw_load),
      .load_val_i(load_val),
      .hw_q_o    (hw_q_o),
      .xfer_o    (xfer_o)
   );

   always_comb begin
      rdata_o = '0;
      for (int s = 0; s < SLICES; s++) begin
         if (rd_hit[s]) begin
            rdata_o = rdata_o | (cap_en ? hw_d_i[s*DATA_W +: DATA_W]
                                        : buf_q[s*DATA_W +: DATA_W]);
         end
      end
   end
endmodule

// File: rtl/wide_reg_stage_chk.sv
module wide_reg_stage_chk
   import wbuf_pkg::*;
#(
   parameter int    DATA_W    = 32,
   parameter int    SLICES    = 4,
   parameter int    ADDR_W    = 8,
   parameter int    BASE_ADDR = 'h40,
   parameter trig_e TRIG      = TRIG_WR_MSB
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        addr_i,
   input logic                     wr_i,
   input logic                     rd_i,
   input logic                     trig_i,
   input logic [DATA_W-1:0]        rdata_o,
   input logic [DATA_W*SLICES-1:0] hw_q_o,
   input logic [DATA_W*SLICES-1:0] hw_d_i,
   input logic                     xfer_o
);
   localparam int STRIDE = DATA_W / 8;
   localparam int TIDX   = (TRIG == TRIG_WR_LSB || TRIG == TRIG_RD_LSB) ? 0 : SLICES - 1;
   localparam logic [ADDR_W-1:0] TADDR = ADDR_W'(BASE_ADDR + TIDX*STRIDE);

   logic in_map;
   always_comb begin
      in_map = 1'b0;
      for (int s = 0; s < SLICES; s++) begin
         if (addr_i == ADDR_W'(BASE_ADDR + s*STRIDE)) in_map = 1'b1;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hw_q_o == '0 && !xfer_o));

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !in_map) |-> (rdata_o == '0));

   p_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_o |-> $stable(hw_q_o));

   if (TRIG == TRIG_WR_LSB || TRIG == TRIG_WR_MSB) begin : g_wr
      p_wr_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && addr_i == TADDR) |=> xfer_o);
      p_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_i && addr_i == TADDR) |=> !xfer_o);
   end else if (TRIG == TRIG_EXT) begin : g_ext
      p_ext_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
         trig_i |=> xfer_o);
      p_ext_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !trig_i |=> !xfer_o);
   end else begin : g_rd
      p_rd_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_i && addr_i == TADDR) |-> (rdata_o == hw_d_i[TIDX*DATA_W +: DATA_W]));
      p_rd_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_i && addr_i == TADDR) |=> xfer_o);
      p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         hw_q_o == '0);
   end
endmodule

bind wide_reg_stage wide_reg_stage_chk #(
   .DATA_W   (DATA_W),
   .SLICES   (SLICES),
   .ADDR_W   (ADDR_W),
   .BASE_ADDR(BASE_ADDR),
   .TRIG     (TRIG)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr_i (addr_i),
   .wr_i   (wr_i),
   .rd_i   (rd_i),
   .trig_i (trig_i),
   .rdata_o(rdata_o),
   .hw_q_o (hw_q_o),
   .hw_d_i (hw_d_i),
   .xfer_o (xfer_o)
);

// File: tb/wide_reg_stage_tb.sv
module wide_reg_stage_tb;
   import wbuf_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   addr = '0;
   logic         wr = 1'b0;
   logic         rd = 1'b0;
   logic [31:0]  wdata = '0;
   logic [3:0]   be = '0;
   logic         trig = 1'b0;
   logic [127:0] hw_d = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   logic [31:0]  dut_rd, wl_rd, rl_rd, rm_rd, ext_rd;
   logic [127:0] dut_hw, rl_hw, ext_hw;
   logic [63:0]  wl_hw;
   logic [95:0]  rm_hw;
   logic         dut_x, wl_x, rl_x, rm_x, ext_x;

   wide_reg_stage #(.SLICES(4), .BASE_ADDR('h40), .TRIG(TRIG_WR_MSB)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .be_i(be), .rdata_o(dut_rd), .trig_i(trig), .hw_q_o(dut_hw), .hw_d_i(hw_d), .xfer_o(dut_x));
   wide_reg_stage #(.SLICES(2), .BASE_ADDR('h80), .TRIG(TRIG_WR_LSB)) u_dut_wl (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .be_i(be), .rdata_o(wl_rd), .trig_i(trig), .hw_q_o(wl_hw), .hw_d_i(hw_d[63:0]), .xfer_o(wl_x));
   wide_reg_stage #(.SLICES(4), .BASE_ADDR('hC0), .TRIG(TRIG_RD_LSB)) u_dut_rl (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .be_i(be), .rdata_o(rl_rd), .trig_i(trig), .hw_q_o(rl_hw), .hw_d_i(hw_d), .xfer_o(rl_x));
   wide_reg_stage #(.SLICES(3), .BASE_ADDR('h20), .TRIG(TRIG_RD_MSB)) u_dut_rm (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .be_i(be), .rdata_o(rm_rd), .trig_i(trig), .hw_q_o(rm_hw), .hw_d_i(hw_d[95:0]), .xfer_o(rm_x));
   wide_reg_stage #(.SLICES(4), .BASE_ADDR('h00), .TRIG(TRIG_EXT)) u_dut_ext (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .be_i(be), .rdata_o(ext_rd), .trig_i(trig), .hw_q_o(ext_hw), .hw_d_i(hw_d), .xfer_o(ext_x));

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
      @(negedge clk);
      addr = a; wdata = d; be = m; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_begin(input logic [7:0] a);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #2;
   endtask

   task automatic bus_idle();
      @(negedge clk);
      rd = 1'b0; wr = 1'b0; trig = 1'b0;
   endtask

   // R9 monitor: wide outputs may only move in a pulse cycle
   logic [127:0] prev_dut, prev_ext;
   always @(negedge clk) begin
      if (rst_n) begin
         if (dut_hw !== prev_dut) check("R9 dut change outside pulse", {127'd0, dut_x}, 128'd1);
         if (ext_hw !== prev_ext) check("R9 ext change outside pulse", {127'd0, ext_x}, 128'd1);
      end
      prev_dut = dut_hw;
      prev_ext = ext_hw;
   end

   task automatic t_reset();
      check("R1 hw_q zero", dut_hw, '0);
      check("R1 ext hw_q zero", ext_hw, '0);
      check("R1 xfer low", {127'd0, dut_x}, '0);
      rd_begin(8'h4C);
      check("R1 buffer zero", {96'd0, dut_rd}, '0);
      bus_idle();
   endtask

   task automatic t_merge();
      bus_wr(8'h40, 32'h11223344, 4'hF);
      rd_begin(8'h40);
      check("R3 full write", {96'd0, dut_rd}, {96'd0, 32'h11223344});
      bus_idle();
      bus_wr(8'h40, 32'hAABBCCDD, 4'b0101);
      rd_begin(8'h40);
      check("R3 byte merge", {96'd0, dut_rd}, {96'd0, 32'h11BB33DD});
      check("R4 read shows buffer not hw", dut_hw, '0);
      bus_idle();
   endtask

   task automatic t_decode();
      bus_wr(8'h42, 32'hFFFFFFFF, 4'hF);
      bus_wr(8'h3C, 32'hFFFFFFFF, 4'hF);
      bus_wr(8'h50, 32'hFFFFFFFF, 4'hF);
      rd_begin(8'h40);
      check("R2 stray writes ignored", {96'd0, dut_rd}, {96'd0, 32'h11BB33DD});
      bus_idle();
      rd_begin(8'h42);
      check("R2 misaligned read zero", {96'd0, dut_rd}, '0);
      bus_idle();
      rd_begin(8'h50);
      check("R2 past-end read zero", {96'd0, dut_rd}, '0);
      bus_idle();
   endtask

   task automatic t_commit_msb();
      bus_wr(8'h44, 32'h22222222, 4'hF);
      bus_wr(8'h48, 32'h33333333, 4'hF);
      check("R5 no commit on middle writes", dut_hw, '0);
      bus_wr(8'h4C, 32'hDEAD0003, 4'hF);
      check("R5 atomic commit", dut_hw, {32'hDEAD0003, 32'h33333333, 32'h22222222, 32'h11BB33DD});
      check("R8 pulse in update cycle", {127'd0, dut_x}, 128'd1);
      @(negedge clk);
      check("R8 pulse one cycle", {127'd0, dut_x}, '0);
      bus_wr(8'h40, 32'h44444444, 4'hF);
      check("R5 low write no commit", dut_hw, {32'hDEAD0003, 32'h33333333, 32'h22222222, 32'h11BB33DD});
      bus_wr(8'h4C, 32'h0000BEEF, 4'b0011);
      check("R5 merged trigger slice", dut_hw, {32'hDEADBEEF, 32'h33333333, 32'h22222222, 32'h44444444});
   endtask

   task automatic t_commit_lsb();
      bus_wr(8'h84, 32'h00000055, 4'hF);
      check("R5 wl high write no commit", {64'd0, wl_hw}, '0);
      bus_wr(8'h80, 32'h00000066, 4'hF);
      check("R5 wl commit on low", {64'd0, wl_hw}, {64'd0, 32'h55, 32'h66});
      check("R8 wl pulse", {127'd0, wl_x}, 128'd1);
   endtask

   task automatic t_capture_lsb();
      hw_d = {32'hA4A4A4A4, 32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1};
      bus_wr(8'hC8, 32'h00000077, 4'hF);
      rd_begin(8'hC8);
      check("R4 rl read buffer", {96'd0, rl_rd}, {96'd0, 32'h77});
      bus_idle();
      rd_begin(8'hC0);
      check("R6 rl trigger read live", {96'd0, rl_rd}, {96'd0, 32'hA1A1A1A1});
      bus_idle();
      check("R8 rl capture pulse", {127'd0, rl_x}, 128'd1);
      check("R6 rl hw_q held zero", rl_hw, '0);
      hw_d = {32'hB4B4B4B4, 32'hB3B3B3B3, 32'hB2B2B2B2, 32'hB1B1B1B1};
      rd_begin(8'hC8);
      check("R6 rl snapshot slice2", {96'd0, rl_rd}, {96'd0, 32'hA3A3A3A3});
      bus_idle();
      rd_begin(8'hCC);
      check("R6 rl snapshot slice3", {96'd0, rl_rd}, {96'd0, 32'hA4A4A4A4});
      bus_idle();
   endtask

   task automatic t_capture_msb();
      rd_begin(8'h28);
      check("R6 rm trigger read live", {96'd0, rm_rd}, {96'd0, 32'hB3B3B3B3});
      bus_idle();
      hw_d = '1;
      rd_begin(8'h20);
      check("R6 rm snapshot low", {96'd0, rm_rd}, {96'd0, 32'hB1B1B1B1});
      check("R8 rm no pulse on low read", {127'd0, rm_x}, '0);
      bus_idle();
   endtask

   task automatic t_external();
      bus_wr(8'h00, 32'h10, 4'hF);
      bus_wr(8'h04, 32'h20, 4'hF);
      bus_wr(8'h08, 32'h30, 4'hF);
      bus_wr(8'h0C, 32'h40, 4'hF);
      check("R7 bus writes no commit", ext_hw, '0);
      @(negedge clk);
      addr = 8'h00; wdata = 32'h99; be = 4'hF; wr = 1'b1; trig = 1'b1;
      bus_idle();
      check("R7 commit uses pre-write buffer", ext_hw, {32'h40, 32'h30, 32'h20, 32'h10});
      check("R8 ext pulse", {127'd0, ext_x}, 128'd1);
      @(negedge clk);
      trig = 1'b1;
      bus_idle();
      check("R7 second trigger", ext_hw, {32'h40, 32'h30, 32'h20, 32'h99});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_merge();
      t_decode();
      t_commit_msb();
      t_commit_lsb();
      t_capture_lsb();
      t_capture_msb();
      t_external();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule